// File: doc/BRIEF.md
# Binary Field Inverter by Fermat Exponentiation

This block returns the multiplicative inverse of an element of GF(2^m). Elements use the ordinary polynomial basis. The reduction polynomial is x^m plus a parameter vector of its lower terms, and the default is x^113 + x^9 + 1. Because a^(2^m - 1) = 1 for any nonzero a, the block computes the inverse as a^(2^m - 2).

The block reaches that power through an Itoh–Tsujii chain of values a^(2^k - 1), with k derived from the bits of m - 1. A doubling step squares the running value k times and then multiplies it by the value saved before those squarings. An increment step squares once and then multiplies by the operand. One extra squaring at the end of the chain gives the inverse. For m = 113, k runs through 1, 2, 3, 6, 7, 14, 28, 56 and 112, which takes 112 squarings and 8 multiplications.

A single combinational multiplier and a single squarer are reused by a small sequencer that does one field operation per clock. The schedule never depends on the operand, so the latency is a fixed constant.

Top module: `gf2m_inverter`

## Requirements
- R1: For every nonzero operand a, the result r satisfies a·r = 1 in GF(2^m), where the product is reduced by x^m + POLY (default m = 113, POLY = 0x201, that is x^9 + 1).
- R2: An operand of zero gives a result of zero.
- R3: `done` is high for exactly one cycle. It rises a fixed (m - 1) + NMUL clock edges after the edge that accepted `start`, where NMUL is the number of multiplications in the chain. That is 120 edges for m = 113 and 9 edges for m = 7.
- R4: `busy` is high from the cycle after `start` is accepted until the cycle in which `done` is high, and `busy` is low in that cycle.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The running operation keeps its operand and its latency, and no second `done` follows.
- R6: `result` holds its value from one `done` to the next, whatever the inputs do in between.
- R7: While reset is held, and right after it, `busy` is 0, `done` is 0 and `result` is 0.
- R8: Parameters M and POLY select the field. With M = 7 and POLY = 0x03 (x^7 + x + 1), R1 to R3 hold for all 128 operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an inversion; sampled only while idle |
| operand | input | M | Element to invert, polynomial basis |
| busy | output | 1 | An inversion is running |
| done | output | 1 | One-cycle pulse: `result` is new |
| result | output | M | Inverse of the last accepted operand |

## Verification
The hardest thing to reach from the ports is the set of increment steps in the chain. In these steps the running value is multiplied by the operand rather than by the value saved before the squarings. With m = 113 they occur only twice, and a wrong branch there still produces a plausible-looking 113-bit result. The bench therefore also builds a 7-bit field, where m - 1 = 6 takes the same mix of doubling and increment steps. It sweeps all 128 operands there and checks every product against a bit-serial multiplier. At full width it checks random operands, the extremes 1 and x^112, and a `start` pulse injected partway through a run.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

   typedef enum logic [1:0] {ST_IDLE, ST_SQR, ST_MUL} inv_state_e;
   typedef enum logic [1:0] {PH_DBL, PH_ADD, PH_FIN} inv_phase_e;

   // position of the leading one of a positive value
   function automatic int lead_pos(input int v);
      int p;
      p = 0;
      for (int i = 0; i < 31; i++)
         if (((v >> i) & 1) == 1) p = i;
      return p;
   endfunction

   // multiplications used by the chain for exponent m-1
   function automatic int chain_mults(input int m);
      int e, n, top;
      e   = m - 1;
      n   = 0;
      top = lead_pos(e);
      for (int i = top - 1; i >= 0; i--) begin
         n++;
         if (((e >> i) & 1) == 1) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/gf2m_mul.sv
module gf2m_mul #(
   parameter int          M    = 113,
   parameter logic [M-1:0] POLY = M'(10'h201)
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] y
);
   logic [M-1:0] p;

   // MSB-first shift-and-add with reduction folded into every step
   always_comb begin
      p = '0;
      for (int i = M - 1; i >= 0; i--) begin
         p = {p[M-2:0], 1'b0} ^ (p[M-1] ? POLY : '0) ^ (b[i] ? a : '0);
      end
      y = p;
   end
endmodule

// File: rtl/gf2m_sqr.sv
module gf2m_sqr #(
   parameter int          M    = 113,
   parameter logic [M-1:0] POLY = M'(10'h201)
) (
   input  logic [M-1:0] a,
   output logic [M-1:0] y
);
   localparam int SW = 2 * M - 1;
   logic [SW-1:0] s;

   // squaring spreads bits to even positions; high terms fold down
   always_comb begin
      s = '0;
      for (int i = 0; i < M; i++) s[2*i] = a[i];
      for (int j = SW - 1; j >= M; j--) begin
         if (s[j]) s[j-M +: M] = s[j-M +: M] ^ POLY;
      end
      y = s[M-1:0];
   end
endmodule

// File: rtl/gf2m_inverter.sv
module gf2m_inverter #(
   parameter int           M             = 113,
   parameter logic [M-1:0] POLY          = M'(10'h201),
   parameter bit           SQR_DEDICATED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] operand,
   output logic         busy,
   output logic         done,
   output logic [M-1:0] result
);
   import gfinv_pkg::*;

   localparam int KW     = $clog2(M) + 1;
   localparam int MSBPOS = lead_pos(M - 1);
   localparam int IW     = (MSBPOS > 1) ? $clog2(MSBPOS) : 1;
   localparam int NMUL   = chain_mults(M);
   localparam int LAT    = (M - 1) + NMUL;
   localparam int LW     = $clog2(LAT + 1) + 1;
   localparam logic [KW-1:0] EXP = KW'(M - 1);

   if (M < 3) begin : g_bad_width
      $error("gf2m_inverter: M must be at least 3");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("gf2m_inverter: POLY must contain the constant term");
   end

   inv_state_e   st;
   inv_phase_e   ph;
   logic [M-1:0] acc, save, base;
   logic [KW-1:0] cnt, k;
   logic [IW-1:0] idx;
   logic [M-1:0] mul_b, mul_out, sq_out;
   logic [KW-1:0] k_next;

   assign mul_b  = (ph == PH_DBL) ? save : base;
   assign k_next = (ph == PH_DBL) ? (k << 1) : (k + KW'(1));

   gf2m_mul #(.M(M), .POLY(POLY)) u_mul (.a(acc), .b(mul_b), .y(mul_out));

   if (SQR_DEDICATED) begin : g_sqr_wired
      gf2m_sqr #(.M(M), .POLY(POLY)) u_sqr (.a(acc), .y(sq_out));
   end else begin : g_sqr_mul
      gf2m_mul #(.M(M), .POLY(POLY)) u_sqr (.a(acc), .b(acc), .y(sq_out));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_DBL;
         acc    <= '0;
         save   <= '0;
         base   <= '0;
         cnt    <= '0;
         k      <= '0;
         idx    <= '0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  acc  <= operand;
                  base <= operand;
                  save <= operand;
                  k    <= KW'(1);
                  cnt  <= KW'(1);
                  idx  <= IW'(MSBPOS - 1);
                  ph   <= PH_DBL;
                  st   <= ST_SQR;
               end
            end
            ST_SQR: begin
               acc <= sq_out;
               cnt <= cnt - KW'(1);
               if (cnt == KW'(1)) begin
                  if (ph == PH_FIN) begin
                     result <= sq_out;
                     done   <= 1'b1;
                     st     <= ST_IDLE;
                  end else begin
                     st <= ST_MUL;
                  end
               end
            end
            ST_MUL: begin
               acc <= mul_out;
               k   <= k_next;
               st  <= ST_SQR;
               if (ph == PH_DBL && EXP[idx]) begin
                  ph  <= PH_ADD;
                  cnt <= KW'(1);
               end else if (idx == '0) begin
                  ph  <= PH_FIN;
                  cnt <= KW'(1);
               end else begin
                  idx  <= idx - IW'(1);
                  ph   <= PH_DBL;
                  save <= mul_out;
                  cnt  <= k_next;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);

   // ---------------- checking ----------------
   logic [LW-1:0] lat_cnt;
   logic [LW-1:0] mul_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         mul_cnt <= '0;
      end else if (!busy) begin
         lat_cnt <= '0;
         mul_cnt <= '0;
      end else begin
         lat_cnt <= lat_cnt + LW'(1);
         if (st == ST_MUL) mul_cnt <= mul_cnt + LW'(1);
      end
   end

   assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == LW'(LAT)));
   assert_mul_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mul_cnt == LW'(NMUL)));
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_operand_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(base));
   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result));
   assert_zero_maps_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((base == '0) == (result == '0)));

endmodule

// File: tb/gf2m_inverter_test.sv
module gf2m_inverter_test;
   localparam int BM = 113;
   localparam logic [BM-1:0] BPOLY = 113'h201;
   localparam int BLAT = 120;
   localparam int SM = 7;
   localparam logic [SM-1:0] SPOLY = 7'h03;
   localparam int SLAT = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          b_start = 1'b0;
   logic [BM-1:0] b_op = '0;
   logic          b_busy, b_done;
   logic [BM-1:0] b_res;
   logic          s_start = 1'b0;
   logic [SM-1:0] s_op = '0;
   logic          s_busy, s_done;
   logic [SM-1:0] s_res;

   gf2m_inverter #(.M(BM), .POLY(BPOLY)) uut (
      .clk(clk), .rst_n(rst_n), .start(b_start), .operand(b_op),
      .busy(b_busy), .done(b_done), .result(b_res));

   gf2m_inverter #(.M(SM), .POLY(SPOLY), .SQR_DEDICATED(1'b0)) uut_small (
      .clk(clk), .rst_n(rst_n), .start(s_start), .operand(s_op),
      .busy(s_busy), .done(s_done), .result(s_res));

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog: run did not finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input string act, input string exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endtask

   // bit-serial reference multipliers, LSB of b first
   function automatic logic [BM-1:0] bmul(input logic [BM-1:0] a, input logic [BM-1:0] b);
      logic [BM-1:0] acc = '0;
      logic [BM-1:0] t = a;
      for (int i = 0; i < BM; i++) begin
         if (b[i]) acc ^= t;
         t = {t[BM-2:0], 1'b0} ^ (t[BM-1] ? BPOLY : '0);
      end
      return acc;
   endfunction

   function automatic logic [SM-1:0] smul(input logic [SM-1:0] a, input logic [SM-1:0] b);
      logic [SM-1:0] acc = '0;
      logic [SM-1:0] t = a;
      for (int i = 0; i < SM; i++) begin
         if (b[i]) acc ^= t;
         t = {t[SM-2:0], 1'b0} ^ (t[SM-1] ? SPOLY : '0);
      end
      return acc;
   endfunction

   // returns edges from accepting start until done; optional mid-run start
   task automatic run_big(input logic [BM-1:0] a, input bit inject, output int lat,
                          output logic [BM-1:0] r);
      int n = 0;
      @(negedge clk);
      b_start = 1'b1;
      b_op = a;
      lat = -1;
      while (n < 400) begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            b_start = 1'b0;
            chk(b_busy === 1'b1, "R4 busy after start", $sformatf("%b", b_busy), "1");
         end
         if (inject && n == 40) begin
            b_start = 1'b1;
            b_op = ~a;
         end
         if (inject && n == 41) b_start = 1'b0;
         if (b_done) begin
            lat = n - 1;
            break;
         end
      end
      r = b_res;
      chk(b_busy === 1'b0, "R4 busy low at done", $sformatf("%b", b_busy), "0");
   endtask

   task automatic run_small(input logic [SM-1:0] a, output int lat, output logic [SM-1:0] r);
      int n = 0;
      @(negedge clk);
      s_start = 1'b1;
      s_op = a;
      lat = -1;
      while (n < 100) begin
         @(negedge clk);
         n++;
         if (n == 1) s_start = 1'b0;
         if (s_done) begin
            lat = n - 1;
            break;
         end
      end
      r = s_res;
   endtask

   initial begin
      int lat;
      logic [BM-1:0] r, a, held;
      logic [SM-1:0] sr;
      bit extra;

      // R7: reset state
      repeat (3) @(negedge clk);
      chk(b_busy === 1'b0 && b_done === 1'b0 && b_res === '0, "R7 reset state",
          $sformatf("busy=%b done=%b res=%h", b_busy, b_done, b_res), "0 0 0");
      rst_n = 1'b1;
      @(negedge clk);
      chk(b_busy === 1'b0 && b_done === 1'b0 && s_res === '0, "R7 after release",
          $sformatf("busy=%b done=%b", b_busy, b_done), "0 0");

      // R8: exhaustive sweep of the 7-bit field (x^7+x+1)
      for (int v = 0; v < 128; v++) begin
         run_small(SM'(v), lat, sr);
         chk(lat == SLAT, "R3 R8 small latency", $sformatf("%0d", lat), $sformatf("%0d", SLAT));
         if (v == 0)
            chk(sr === '0, "R2 R8 zero in small field", $sformatf("%h", sr), "0");
         else
            chk(smul(SM'(v), sr) === SM'(1), "R1 R8 small product",
                $sformatf("a=%h r=%h prod=%h", v, sr, smul(SM'(v), sr)), "1");
      end

      // R1/R3: full-width corner and random operands
      for (int t = 0; t < 30; t++) begin
         if (t == 0) a = BM'(1);
         else if (t == 1) a = BM'(2);
         else if (t == 2) a = {1'b1, {(BM-1){1'b0}}};
         else if (t == 3) a = '1;
         else a = {$urandom, $urandom, $urandom, $urandom} ^ BM'(t);
         if (a == '0) a = BM'(5);
         run_big(a, 1'b0, lat, r);
         chk(lat == BLAT, "R3 latency", $sformatf("%0d", lat), $sformatf("%0d", BLAT));
         chk(bmul(a, r) === BM'(1), "R1 product", $sformatf("%h", bmul(a, r)), "1");
         if (t == 0) chk(r === BM'(1), "R1 inverse of one", $sformatf("%h", r), "1");
      end

      // R2: zero operand
      run_big('0, 1'b0, lat, r);
      chk(r === '0, "R2 zero operand", $sformatf("%h", r), "0");
      chk(lat == BLAT, "R3 latency zero", $sformatf("%0d", lat), $sformatf("%0d", BLAT));

      // R5: start during a run is ignored
      a = 113'h1_2345_6789_abcd_ef01_2345_6789_abcd;
      run_big(a, 1'b1, lat, r);
      chk(lat == BLAT, "R5 latency with stray start", $sformatf("%0d", lat), $sformatf("%0d", BLAT));
      chk(bmul(a, r) === BM'(1), "R5 result of first operand", $sformatf("%h", bmul(a, r)), "1");
      extra = 1'b0;
      held = b_res;
      for (int c = 0; c < 150; c++) begin
         @(negedge clk);
         if (b_done || b_busy) extra = 1'b1;
         if (c == 10) b_op = ~b_op;
      end
      chk(!extra, "R5 no second operation", $sformatf("%b", extra), "0");
      chk(b_res === held, "R6 result held", $sformatf("%h", b_res), $sformatf("%h", held));

      // R3: done lasts one cycle
      run_big(BM'(3), 1'b0, lat, r);
      @(negedge clk);
      chk(b_done === 1'b0, "R3 done single cycle", $sformatf("%b", b_done), "0");
      chk(bmul(BM'(3), r) === BM'(1), "R1 product of x+1", $sformatf("%h", bmul(BM'(3), r)), "1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule